// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block predicts the next fetch address during the same cycle that a fetch address is presented. It is a direct-mapped table. The word-index bits of the fetch PC (the bits just above the two byte-offset bits) select a slot. The upper PC bits are compared with a stored tag. Each slot holds four things: a valid flag, that tag, the destination that the branch reached the last time it was taken, and a 2-bit saturating confidence counter. A lookup that matches a valid slot whose counter is in the upper half predicts a redirect to the stored destination. Every other lookup predicts fall-through to PC+4. The answer is available before the instruction is decoded.

Resolved branches come back from the execute stage on a valid/ready update stream. The update side never back-pressures: `upd_ready` is held high, and each beat with `upd_valid` high is consumed on that clock edge. Lookups see the effect from the next cycle onward. A resolved branch whose slot matches moves its counter one step toward the observed direction. If that branch was taken, the stored destination is also refreshed. A branch with no matching slot is written into the table only when it resolved taken. It then replaces whatever occupied its slot. A branch that resolves not-taken and has no matching slot leaves the table untouched.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is invalid, so every lookup reports `lk_hit`=0, `lk_taken`=0 and `lk_next_pc`=`lk_pc`+4.
- R2: A lookup with no valid matching slot reports `lk_hit`=0 and `lk_taken`=0. `lk_taken` is never 1 while `lk_hit` is 0.
- R3: A taken resolution for a PC with no matching slot fills the slot given by PC bits [IDX_W+1:2]. The fill stores tag PC[ADDR_W-1:IDX_W+2], the actual destination, and counter 2'b10. A later lookup of that PC reports a hit, taken, and that destination.
- R4: A not-taken resolution for a PC with no matching slot changes nothing. A later lookup of that PC still misses.
- R5: On a matching slot, a taken resolution increments the counter and stops at 2'b11. A not-taken resolution decrements it and stops at 2'b00. Counter values 2'b10 and 2'b11 predict taken; 2'b00 and 2'b01 predict not-taken.
- R6: Starting from counter 2'b11, two consecutive not-taken resolutions are needed before the prediction turns to not-taken.
- R7: A lookup whose index matches a valid slot but whose tag differs reports a miss.
- R8: A taken resolution on a matching slot replaces the stored destination with the new actual destination.
- R9: When an update and a lookup address the same slot in one cycle, the lookup reports the slot contents from before that update.
- R10: `lk_next_pc` equals `lk_target` when `lk_taken` is 1, and `lk_pc`+4 otherwise. `lk_target` is only meaningful while `lk_hit` is 1.
- R11: `upd_ready` is 1 whenever reset is released, and every beat with `upd_valid` high is applied at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all valid flags |
| lk_pc | input | ADDR_W | Fetch-stage PC to look up |
| lk_hit | output | 1 | A valid slot with a matching tag was found |
| lk_taken | output | 1 | Redirect predicted (hit and counter in upper half) |
| lk_target | output | ADDR_W | Stored destination of the matching slot |
| lk_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | Resolved-branch beat present |
| upd_ready | output | 1 | Update stream accepted (always 1 out of reset) |
| upd_pc | input | ADDR_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Actual destination when taken |

## Verification
Directed sequences run one branch through its whole life, and each sequence separates one failure mode from the others:
- Allocation versus no allocation, by resolving a missing branch first not-taken and then taken.
- Hysteresis versus a single-bit flip, by walking the counter from saturated taken down to saturated not-taken and back.
- Aliasing versus a tag match, by looking up a second PC that shares the index.
- Old contents versus new contents, by making an update and a lookup collide in one cycle.

A long random phase then draws PCs from a small pool spread over three tags and four indices, so that collisions, evictions and counter saturation occur often. This phase catches errors in the order in which updates and lookups interact.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // Counter value written when a taken branch claims a slot.
  localparam ctr_t CTR_FILL = CTR_WEAK_T;

  function automatic logic ctr_predicts_taken(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/btb_index_split.sv
module btb_index_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W - 2
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  // The two low bits are the byte offset inside a 32-bit instruction word.
  assign idx = pc[IDX_W+1:2];
  assign tag = pc[ADDR_W-1:IDX_W+2];
endmodule

// File: rtl/btb_ctr_step.sv
module btb_ctr_step
  import btb_pkg::*;
(
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt
);
  always_comb begin
    nxt = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
    end else begin
      if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
    end
  end
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  localparam int TAG_W   = ADDR_W - IDX_W - 2,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup read port
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_vld,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [ADDR_W-1:0] ra_tgt,
  output ctr_t              ra_ctr,
  // update read port
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_vld,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [ADDR_W-1:0] rb_tgt,
  output ctr_t              rb_ctr,
  // write port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  ctr_t              wr_ctr
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  ctr_t               ctr_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
      end else if (sel) begin
        vld_q[e] <= 1'b1;
      end
    end

    // Payload needs no reset: it is only observed through vld_q.
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e] <= wr_tag;
        tgt_q[e] <= wr_tgt;
        ctr_q[e] <= wr_ctr;
      end
    end
  end

  assign ra_vld = vld_q[ra_idx];
  assign ra_tag = tag_q[ra_idx];
  assign ra_tgt = tgt_q[ra_idx];
  assign ra_ctr = ctr_q[ra_idx];

  assign rb_vld = vld_q[rb_idx];
  assign rb_tag = tag_q[rb_idx];
  assign rb_tgt = tgt_q[rb_idx];
  assign rb_ctr = ctr_q[rb_idx];
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  output logic [ADDR_W-1:0] lk_next_pc,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;

  logic              ra_vld, rb_vld;
  logic [TAG_W-1:0]  ra_tag, rb_tag;
  logic [ADDR_W-1:0] ra_tgt, rb_tgt;
  ctr_t              ra_ctr, rb_ctr;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_tgt;
  ctr_t              wr_ctr, stepped_ctr;
  logic              up_hit, up_fire;

  btb_index_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_split (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
  );

  btb_index_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_up_split (
    .pc(upd_pc), .idx(up_idx), .tag(up_tag)
  );

  btb_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(lk_idx), .ra_vld(ra_vld), .ra_tag(ra_tag), .ra_tgt(ra_tgt), .ra_ctr(ra_ctr),
    .rb_idx(up_idx), .rb_vld(rb_vld), .rb_tag(rb_tag), .rb_tgt(rb_tgt), .rb_ctr(rb_ctr),
    .wr_en(wr_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr)
  );

  btb_ctr_step u_step (.cur(rb_ctr), .taken(upd_taken), .nxt(stepped_ctr));

  // Lookup side: purely combinational on the registered table, so a
  // same-cycle write is not visible until the following cycle.
  always_comb begin
    lk_hit     = ra_vld && (ra_tag == lk_tag);
    lk_taken   = lk_hit && ctr_predicts_taken(ra_ctr);
    lk_target  = ra_tgt;
    lk_next_pc = lk_taken ? ra_tgt : lk_pc + ADDR_W'(4);
  end

  // Update side: never stalls the resolve stream.
  assign upd_ready = 1'b1;
  assign up_fire   = upd_valid && upd_ready;
  assign up_hit    = rb_vld && (rb_tag == up_tag);

  always_comb begin
    wr_en  = 1'b0;
    wr_ctr = CTR_FILL;
    wr_tgt = upd_target;
    if (up_fire) begin
      if (up_hit) begin
        wr_en  = 1'b1;
        wr_ctr = stepped_ctr;
        wr_tgt = upd_taken ? upd_target : rb_tgt;
      end else if (upd_taken) begin
        wr_en  = 1'b1;
        wr_ctr = CTR_FILL;
        wr_tgt = upd_target;
      end
    end
  end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              lk_hit,
  input logic              lk_taken,
  input logic [ADDR_W-1:0] lk_target,
  input logic [ADDR_W-1:0] lk_next_pc,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> lk_hit);

  // R10
  next_pc_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_next_pc == (lk_taken ? lk_target : lk_pc + ADDR_W'(4)));

  // R11
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> upd_ready);

  // R3
  taken_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(upd_valid && upd_taken) && lk_pc == $past(upd_pc))
      |-> (lk_hit && lk_target == $past(upd_target)));

  // R5
  taken_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(upd_valid && upd_taken && lk_taken && lk_pc == upd_pc)
      && lk_pc == $past(lk_pc)) |-> lk_taken);

  // R6
  nottaken_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(upd_valid && !upd_taken && !lk_taken && lk_pc == upd_pc)
      && lk_pc == $past(lk_pc)) |-> !lk_taken);
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/btb_predictor_bench.sv
`timescale 1ns/1ps
module btb_predictor_bench;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int NE = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] lk_pc = '0, upd_pc = '0, upd_target = '0;
  logic          upd_valid = 1'b0, upd_taken = 1'b0;
  logic          lk_hit, lk_taken, upd_ready;
  logic [AW-1:0] lk_target, lk_next_pc;

  int checks = 0;
  int errors = 0;

  // reference table
  logic          m_vld [NE];
  logic [AW-1:0] m_pc  [NE];
  logic [AW-1:0] m_tgt [NE];
  logic [1:0]    m_ctr [NE];

  always #2.5 clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .IDX_W(IW)) u_btb_predictor (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_target(lk_target), .lk_next_pc(lk_next_pc),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  function automatic int idx_of(input logic [AW-1:0] pc);
    return int'(pc[IW+1:2]);
  endfunction

  // full upper-bit compare is the tag compare (index bits already equal)
  function automatic logic m_hit(input logic [AW-1:0] pc);
    int i = idx_of(pc);
    return m_vld[i] && (m_pc[i][AW-1:IW+2] == pc[AW-1:IW+2]);
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cycle(input logic [AW-1:0] lpc, input logic uv,
                       input logic [AW-1:0] upc, input logic ut,
                       input logic [AW-1:0] utg, input string req);
    logic          e_hit, e_tk;
    logic [AW-1:0] e_tgt, e_nx;
    int            i;
    @(negedge clk);
    lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
    #1;
    i     = idx_of(lpc);
    e_hit = m_hit(lpc);
    e_tk  = e_hit && m_ctr[i][1];
    e_tgt = m_tgt[i];
    e_nx  = e_tk ? e_tgt : lpc + 32'd4;
    checks++;
    if (lk_hit !== e_hit || lk_taken !== e_tk || lk_next_pc !== e_nx ||
        (e_hit && lk_target !== e_tgt)) begin
      errors++;
      $display("FAIL %s pc=%h hit/taken/next/tgt = %b/%b/%h/%h expected %b/%b/%h/%h",
               req, lpc, lk_hit, lk_taken, lk_next_pc, lk_target,
               e_hit, e_tk, e_nx, e_tgt);
    end
    @(posedge clk);
    if (uv) begin
      i = idx_of(upc);
      if (m_hit(upc)) begin
        if (ut) begin
          if (m_ctr[i] != 2'b11) m_ctr[i] = m_ctr[i] + 2'd1;
          m_tgt[i] = utg;
        end else if (m_ctr[i] != 2'b00) begin
          m_ctr[i] = m_ctr[i] - 2'd1;
        end
      end else if (ut) begin
        m_vld[i] = 1'b1; m_pc[i] = upc; m_tgt[i] = utg; m_ctr[i] = 2'b10;
      end
    end
  endtask

  task automatic look(input logic [AW-1:0] pc, input string req);
    cycle(pc, 1'b0, '0, 1'b0, '0, req);
  endtask

  task automatic resolve(input logic [AW-1:0] pc, input logic t,
                         input logic [AW-1:0] tg, input string req);
    cycle(pc, 1'b1, pc, t, tg, req);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    logic [AW-1:0] pa, pb;
    int unused;
    for (int k = 0; k < NE; k++) m_vld[k] = 1'b0;
    pa = 32'h0000_1010;            // index 4
    pb = pa + (32'd1 << (IW + 2)); // same index, different tag
    unused = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look(pa, "R1");
    look(32'h8000_0000, "R1");
    // R11: resolve stream never back-pressured
    checks++;
    if (upd_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 upd_ready=%b expected 1", upd_ready);
    end
    // R4: not-taken miss does not allocate
    resolve(pa, 1'b0, 32'h0000_4000, "R2");
    look(pa, "R4");
    // R9: same-cycle lookup sees old (empty) slot
    resolve(pa, 1'b1, 32'h0000_4000, "R9");
    // R3: filled weakly taken
    look(pa, "R3");
    // R5: increment to 11 and stay
    resolve(pa, 1'b1, 32'h0000_4000, "R5");
    resolve(pa, 1'b1, 32'h0000_4000, "R5");
    // R6: two wrong outcomes before the flip
    resolve(pa, 1'b0, 32'h0, "R6");
    look(pa, "R6");
    resolve(pa, 1'b0, 32'h0, "R6");
    look(pa, "R6");
    // R5: decrement saturates at 00
    resolve(pa, 1'b0, 32'h0, "R5");
    resolve(pa, 1'b0, 32'h0, "R5");
    resolve(pa, 1'b1, 32'h0000_5000, "R5");
    look(pa, "R5");
    // R8: taken on a hit rewrites target
    resolve(pa, 1'b1, 32'h0000_6000, "R8");
    look(pa, "R8");
    // R7: aliasing index with a different tag misses
    look(pb, "R7");
    // R10: random mix over three tags and four indices
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] lp, up, tg;
      lp = (AW'($urandom_range(0, 2)) << (IW + 2)) | (AW'($urandom_range(0, 3)) << 2);
      up = (AW'($urandom_range(0, 2)) << (IW + 2)) | (AW'($urandom_range(0, 3)) << 2);
      if ($urandom_range(0, 3) == 0) up = lp;
      tg = $urandom() & 32'hFFFF_FFFC;
      cycle(lp, ($urandom_range(0, 9) < 6), up, $urandom_range(0, 1) == 1, tg, "R10");
    end
    summary();
  end
endmodule